// File: doc/BRIEF.md
# Free-Running Successive-Approximation Conversion Controller

This block sequences an N-bit successive-approximation converter that runs back to back with no start command. While the run-select input is held low, it starts a new conversion as soon as the previous one has finished. For each bit decision, the block drives a trial code to an external DAC and pulses a sample strobe. It then takes the external comparator's decision and finally places the result in an output latch. Chip-select and read serve only to read that latch, so to the host the block looks like a ROM. The data bus is three-state and is driven combinationally whenever both strobes are low.

The block protects the latch against a read in progress. A result normally enters the latch on the clock edge where busy returns high. If the host holds a read across that edge, the update is postponed and conversion stalls with busy high. When either strobe is released, the latch is written and the next conversion follows one internal clock cycle later. The DAC, comparator and analog sampling are outside this block.

The external clock is divided internally by `CLK_DIV`. One internal cycle is one bit decision. Each conversion frame is `WIDTH + 2` internal cycles: `WIDTH` trials, one settling cycle and one busy-high cycle.

Because the host interface is a ROM-style strobe read, it carries no valid/ready handshake. No back-pressure applies other than the deferral described here.

Top module: `sar_freerun_ctrl`

## Requirements
- R1: After reset, busy_n is 1 and the output latch holds 0, so a read returns 8'h00 before any conversion has completed.
- R2: While run_n is 1, no new conversion starts: busy_n stays 1 and sample_stb stays 0. Dropping run_n to 1 mid-conversion lets that conversion finish and update the latch.
- R3: With run_n at 0, and with no read spanning the end of a conversion, busy_n is 0 for (WIDTH+1)*CLK_DIV clocks (18) and then 1 for CLK_DIV clocks (2), repeating every 20 clocks.
- R4: Trials run MSB first from half scale (8'h80 on the first busy-low clock). In internal cycle k, trial_code is the bits already decided OR'd with bit WIDTH-1-k. comp_in is sampled on the last clock of that cycle, and a 1 keeps the bit.
- R5: sample_stb is high for exactly one clock, the first clock of each trial cycle, giving WIDTH (8) pulses per conversion, all while busy_n is 0.
- R6: When no read is active at the edge where busy_n rises, the latch takes the conversion result on that edge, and a later read returns it.
- R7: If cs_n and rd_n are both 0 at the edge where busy_n would rise, the latch keeps its old value. busy_n then stays 1 and no conversion runs for as long as the read lasts.
- R8: On the first clock edge after either cs_n or rd_n returns to 1 during a stall, the latch takes the held result. busy_n stays 1 for CLK_DIV more clocks and then falls for the next conversion.
- R9: dbus drives the latch value whenever cs_n and rd_n are both 0 and is high-impedance otherwise, with no clock involved.
- R10: Reads that do not span the busy_n rising edge, including reads during the busy-high cycle, change neither the frame timing nor the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_n | input | 1 | Low: convert continuously; high: stop after the current conversion |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| comp_in | input | 1 | Comparator decision, 1 when input is at or above trial_code |
| busy_n | output | 1 | Low while a conversion is running |
| sample_stb | output | 1 | One-clock pulse before each bit decision |
| trial_code | output | WIDTH | Code presented to the external DAC |
| dbus | output | WIDTH | Three-state result bus |

## Verification
The bench builds the block with the defaults WIDTH = 8 and CLK_DIV = 2. Because CLK_DIV is 2, the strobe clock and the decision clock of each internal cycle fall on different edges, so the bench can check both the strobe placement and the MSB-first trial sequence. The 20-clock frame is short enough to exercise back-to-back conversions, a stall held for ten clocks and the restart after release within a few hundred cycles. A comparator model against a chosen target value lets the all-ones, all-zeros and mixed codes each be checked end to end.

// File: rtl/sar_freerun_pkg.sv
package sar_freerun_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_DONE  = 2'd2,
    ST_DEFER = 2'd3
  } frc_state_e;
endpackage

// File: rtl/sar_freerun_seq.sv
module sar_freerun_seq
  import sar_freerun_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int CLK_DIV = 2,
  localparam int PHW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int IDXW   = $clog2(WIDTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_n,
  input  logic            rd_active,
  output frc_state_e      state,
  output logic [IDXW-1:0] step,
  output logic            start,
  output logic            strobe,
  output logic            decide,
  output logic            update,
  output logic            busy_n
);
  logic [PHW-1:0] phase;
  logic           ph_last;
  logic           in_trial;

  assign ph_last  = (phase == PHW'(CLK_DIV - 1));
  assign in_trial = (state == ST_CONV) && (step < IDXW'(WIDTH));
  assign start    = !run_n && ((state == ST_IDLE) || ((state == ST_DONE) && ph_last));
  assign strobe   = in_trial && (phase == '0);
  assign decide   = in_trial && ph_last;
  assign update   = !rd_active &&
                    (((state == ST_CONV) && ph_last && (step == IDXW'(WIDTH))) ||
                     (state == ST_DEFER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= '0;
      step   <= '0;
      busy_n <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_CONV;
            phase  <= '0;
            step   <= '0;
            busy_n <= 1'b0;
          end
        end
        ST_CONV: begin
          if (ph_last) begin
            phase <= '0;
            if (step == IDXW'(WIDTH)) begin
              busy_n <= 1'b1;
              state  <= rd_active ? ST_DEFER : ST_DONE;
            end else begin
              step <= step + IDXW'(1);
            end
          end else begin
            phase <= phase + PHW'(1);
          end
        end
        ST_DONE: begin
          if (ph_last) begin
            phase <= '0;
            if (start) begin
              state  <= ST_CONV;
              step   <= '0;
              busy_n <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            phase <= phase + PHW'(1);
          end
        end
        default: begin
          if (!rd_active) begin
            state <= ST_DONE;
            phase <= '0;
          end
        end
      endcase
    end
  end

  AST_STB_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !busy_n); // R5
  AST_DEFER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DEFER) && rd_active) |=> (busy_n && (state == ST_DEFER))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && run_n) |=> (busy_n && !strobe)); // R2
endmodule

// File: rtl/sar_freerun_trial.sv
module sar_freerun_trial #(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             converting,
  input  logic             start,
  input  logic             decide,
  input  logic [IDXW-1:0]  step,
  input  logic             comp_in,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] probe;
  logic [WIDTH-1:0] sar;

  for (genvar i = 0; i < WIDTH; i++) begin : g_probe
    assign probe[i] = (step == IDXW'(WIDTH - 1 - i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar <= '0;
    end else if (start) begin
      sar <= '0;
    end else if (decide) begin
      for (int i = 0; i < WIDTH; i++) begin
        if (probe[i]) sar[i] <= comp_in;
      end
    end
  end

  assign trial_code = converting ? (sar | probe) : HALF;
  assign result     = sar;

  AST_HALF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (trial_code == HALF)); // R4
endmodule

// File: rtl/sar_freerun_latch.sv
module sar_freerun_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [WIDTH-1:0] result,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [WIDTH-1:0] held,
  output wire  [WIDTH-1:0] dbus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (update) held <= result;
  end

  assign dbus = (!cs_n && !rd_n) ? held : {WIDTH{1'bz}};

  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(held)); // R10
endmodule

// File: rtl/sar_freerun_ctrl.sv
module sar_freerun_ctrl
  import sar_freerun_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int CLK_DIV = 2,
  localparam int IDXW   = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             comp_in,
  output logic             busy_n,
  output logic             sample_stb,
  output logic [WIDTH-1:0] trial_code,
  output wire  [WIDTH-1:0] dbus
);
  frc_state_e       state;
  logic [IDXW-1:0]  step;
  logic             start, decide, update, rd_active;
  logic [WIDTH-1:0] result, held;

  assign rd_active = !cs_n && !rd_n;

  sar_freerun_seq #(.WIDTH(WIDTH), .CLK_DIV(CLK_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .rd_active(rd_active),
    .state(state), .step(step), .start(start), .strobe(sample_stb),
    .decide(decide), .update(update), .busy_n(busy_n)
  );

  sar_freerun_trial #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst_n(rst_n), .converting(state == ST_CONV), .start(start),
    .decide(decide), .step(step), .comp_in(comp_in),
    .trial_code(trial_code), .result(result)
  );

  sar_freerun_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .update(update), .result(result),
    .cs_n(cs_n), .rd_n(rd_n), .held(held), .dbus(dbus)
  );

  AST_DEFER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_n) && $past(rd_active)) |-> $stable(held)); // R7
endmodule

// File: tb/test_sar_freerun_ctrl.sv
module test_sar_freerun_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_n = 1'b1;
  logic cs_n = 1'b1;
  logic rd_n = 1'b1;
  logic [7:0] tgt = 8'h00;
  logic comp_in, busy_n, sample_stb;
  logic [7:0] trial_code;
  wire  [7:0] dbus;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;
  assign comp_in = (trial_code <= tgt);

  sar_freerun_ctrl i_sar_freerun_ctrl (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .cs_n(cs_n), .rd_n(rd_n),
    .comp_in(comp_in), .busy_n(busy_n), .sample_stb(sample_stb),
    .trial_code(trial_code), .dbus(dbus)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  function automatic logic [7:0] trial_at(input logic [7:0] v, input int k);
    logic [7:0] acc = 8'h00;
    for (int b = 7; b > 7 - k; b--) begin
      if ((acc | (8'h01 << b)) <= v) acc = acc | (8'h01 << b);
    end
    return acc | (8'h01 << (7 - k));
  endfunction

  task automatic wait_start(input logic [7:0] v);
    while (busy_n !== 1'b1) @(negedge clk);
    tgt = v;
    while (busy_n !== 1'b0) @(negedge clk);
  endtask

  task automatic read_bus(input string tag, input logic [7:0] exp_v);
    cs_n = 1'b0; rd_n = 1'b0;
    #2 chk(tag, dbus, exp_v);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    #2 chk("R9 bus released", dbus, 8'hzz);
  endtask

  task automatic t_reset();
    int lows = 0, stbs = 0;
    rst_n = 1'b0; run_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {7'd0, busy_n}, 8'h01);
    chk("R9 idle bus", dbus, 8'hzz);
    read_bus("R1 latch after reset", 8'h00);
    repeat (30) begin
      @(negedge clk);
      if (!busy_n) lows++;
      if (sample_stb) stbs++;
    end
    chk("R2 no busy while stopped", 8'(lows), 8'd0);
    chk("R2 no strobe while stopped", 8'(stbs), 8'd0);
  endtask

  task automatic t_frame(input logic [7:0] v);
    int lo = 0, hi = 0, stbs = 0, bad = 0;
    run_n = 1'b0;
    wait_start(v);
    chk("R4 half scale first", trial_code, 8'h80);
    while (busy_n === 1'b0 && lo < 100) begin
      if (sample_stb) begin
        if (lo != 2 * stbs) bad++;
        if (trial_code !== trial_at(v, stbs)) bad++;
        stbs++;
      end
      lo++;
      @(negedge clk);
    end
    while (busy_n === 1'b1 && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    chk("R3 busy low length", 8'(lo), 8'd18);
    chk("R3 busy high length", 8'(hi), 8'd2);
    chk("R5 strobe count", 8'(stbs), 8'd8);
    chk("R4 trial sequence and R5 placement", 8'(bad), 8'd0);
    read_bus("R6 result latched", v);
  endtask

  task automatic t_defer(input logic [7:0] prev, input logic [7:0] v);
    int hi = 0, drops = 0;
    wait_start(v);
    repeat (5) @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    while (busy_n === 1'b0) @(negedge clk);
    chk("R7 old data at busy rise", dbus, prev);
    repeat (10) begin
      @(negedge clk);
      if (busy_n !== 1'b1) drops++;
    end
    chk("R7 stalled while reading", 8'(drops), 8'd0);
    chk("R7 latch not updated", dbus, prev);
    cs_n = 1'b1;
    @(negedge clk);
    while (busy_n === 1'b1 && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    rd_n = 1'b1;
    chk("R8 restart delay", 8'(hi), 8'd2);
    read_bus("R8 deferred result", v);
  endtask

  task automatic t_nonoverlap(input logic [7:0] v);
    int lo = 0, hi = 0;
    wait_start(v);
    while (busy_n === 1'b0 && lo < 100) begin
      lo++;
      if (lo == 4 || lo == 9) begin cs_n = 1'b0; rd_n = 1'b0; end
      if (lo == 5 || lo == 10) begin cs_n = 1'b1; rd_n = 1'b1; end
      @(negedge clk);
    end
    cs_n = 1'b0; rd_n = 1'b0;
    #2 chk("R10 read in busy-high cycle", dbus, v);
    while (busy_n === 1'b1 && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    cs_n = 1'b1; rd_n = 1'b1;
    chk("R10 low length with reads", 8'(lo), 8'd18);
    chk("R10 high length with read", 8'(hi), 8'd2);
  endtask

  task automatic t_stop(input logic [7:0] v);
    int lows = 0, stbs = 0;
    wait_start(v);
    repeat (3) @(negedge clk);
    run_n = 1'b1;
    while (busy_n === 1'b0) @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      if (!busy_n) lows++;
      if (sample_stb) stbs++;
    end
    chk("R2 stays stopped", 8'(lows), 8'd0);
    chk("R2 no strobes when stopped", 8'(stbs), 8'd0);
    read_bus("R2 last conversion kept", v);
  endtask

  initial begin : watchdog
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_frame(8'h00);
    t_frame(8'hFF);
    t_frame(8'hA5);
    t_defer(8'hA5, 8'h3C);
    t_nonoverlap(8'h5A);
    t_stop(8'h77);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule